// File: doc/BRIEF.md
# Oversampled SPI Slave

This block is an SPI slave that runs entirely on the system clock. It never uses the incoming serial clock as a clock. The serial clock, the active-low select and the MOSI line each pass through a two-flop synchronizer. A third register stage on the serial clock lets the block see a transition whenever the last two samples differ. Every transition is then classed as a leading or a trailing edge relative to the idle level (CPOL). The phase setting (CPHA) decides which of the two edges samples MOSI and which moves MISO on to the next bit.

Transmit bytes come from a RAM-side source. That source offers a byte together with a valid flag, and a one-cycle take pulse confirms each fetch. Received bytes appear on a parallel bus together with a one-cycle strobe.

The block also copes with three kinds of trouble. If select is released in the middle of a byte, the partial byte is thrown away and an abort is flagged. If the serial clock stalls for longer than a programmable number of system clocks, the frame is ended. If no transmit byte is available when one is needed, the slave sends all ones and flags an underrun. The polarity and phase settings are captured only while no frame is in progress.

Top module: `spi_os_slave`

## Requirements
- R1: A change on `sclk_in` is acted on three system clocks after it is applied: two synchronizer flops plus one edge register. Any serial clock whose half period is at least 8 system clocks is handled without losing edges.
- R2: All four settings of polarity and phase receive correctly. Bits arrive MSB first. After each group of 8 sampled bits, `rx_data` holds the byte and `rx_strobe` is high for exactly one cycle.
- R3: MISO sends each byte MSB first and is stable at the master's sampling edge. With phase 0, the first byte is fetched when select is asserted, and each later fetch happens on the trailing edge that follows an eighth sample. With phase 1, every fetch happens on the leading edge that starts a byte. Each fetch pulses `tx_take` for one cycle.
- R4: If select is deasserted after 1 to 7 bits of a byte, that byte is discarded: there is no `rx_strobe` for it. `abort_flag` is then set and stays set until the next frame starts.
- R5: While a frame is in progress, the block counts system clocks since the last serial-clock transition. When that count reaches `cfg_limit`, the block sets `timeout_flag`, turns MISO off and ignores the serial clock until select is released. The flag is cleared when the next frame starts.
- R6: If `tx_valid` is low when a byte is fetched, the byte sent is 8'hFF and `tx_take` stays low. `underrun` is then set and stays set until the next frame starts.
- R7: `cfg_cpol` and `cfg_cpha` are captured only while the block is idle. Changing them during a frame has no effect on that frame.
- R8: `miso_oe` is high only while a frame is in progress, and `miso_out` is 0 whenever `miso_oe` is low.
- R9: While `rst_n` is low, every output is 0, whatever the inputs do.
- R10: A frame may hold several bytes back to back, each received and strobed in turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | 0: sample on the leading edge; 1: sample on the trailing edge |
| cfg_limit | input | TW | Stall limit, in system clocks |
| sclk_in | input | 1 | Serial clock, treated as data |
| ss_n_in | input | 1 | Slave select, active low |
| mosi_in | input | 1 | Serial data in |
| miso_out | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for MISO |
| tx_data | input | DW | Byte offered by the RAM side |
| tx_valid | input | 1 | `tx_data` is valid |
| tx_take | output | 1 | One-cycle pulse: `tx_data` was consumed |
| rx_data | output | DW | Last byte received |
| rx_strobe | output | 1 | One-cycle pulse: `rx_data` was updated |
| underrun | output | 1 | A fill byte was sent in this frame |
| timeout_flag | output | 1 | This frame ended on a stalled clock |
| abort_flag | output | 1 | This frame ended part-way through a byte |

## Verification
The assertions check the following on every cycle:
- the captured mode stays fixed for the whole of a frame;
- the output enable falls once select has been high long enough;
- an abort never comes with a byte strobe;
- an underrun only ever comes from a fetch made without valid data;
- the output stays off after a timeout.

Bit order, the alignment of MISO in each of the four modes, the fetch counts for each phase, discarding of partial bytes, and the effect of a mid-frame mode change can only be shown by the bench. It does this by playing a master through whole frames.

// File: rtl/spi_os_slave.sv
module spi_os_slave #(
  parameter int DW = 8,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_cpol,
  input  logic          cfg_cpha,
  input  logic [TW-1:0] cfg_limit,
  input  logic          sclk_in,
  input  logic          ss_n_in,
  input  logic          mosi_in,
  output logic          miso_out,
  output logic          miso_oe,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  output logic          tx_take,
  output logic [DW-1:0] rx_data,
  output logic          rx_strobe,
  output logic          underrun,
  output logic          timeout_flag,
  output logic          abort_flag
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  typedef enum logic [1:0] {IDLE, RUN, HALT} st_t;
  st_t st;

  logic [2:0]    sclk_sh;
  logic [1:0]    ss_sh, mosi_sh;
  logic          pol_q, pha_q, need;
  logic [CW-1:0] cnt;
  logic [TW-1:0] tmo;
  logic [DW-1:0] tx_sr, rx_sr;

  logic sel, sedge, lead, trail, samp, shft, in_run;
  assign sel    = ~ss_sh[1];
  assign sedge  = sclk_sh[1] ^ sclk_sh[2];
  assign lead   = sedge & (sclk_sh[1] != pol_q);
  assign trail  = sedge & (sclk_sh[1] == pol_q);
  assign samp   = pha_q ? trail : lead;
  assign shft   = pha_q ? lead : trail;
  assign in_run = (st == RUN);

  assign miso_oe  = in_run;
  assign miso_out = in_run & tx_sr[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sh <= '0;
      ss_sh   <= '1;
      mosi_sh <= '0;
    end else begin
      sclk_sh <= {sclk_sh[1:0], sclk_in};
      ss_sh   <= {ss_sh[0], ss_n_in};
      mosi_sh <= {mosi_sh[0], mosi_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= IDLE;
      pol_q        <= 1'b0;
      pha_q        <= 1'b0;
      need         <= 1'b0;
      cnt          <= '0;
      tmo          <= '0;
      tx_sr        <= '0;
      rx_sr        <= '0;
      rx_data      <= '0;
      rx_strobe    <= 1'b0;
      tx_take      <= 1'b0;
      underrun     <= 1'b0;
      timeout_flag <= 1'b0;
      abort_flag   <= 1'b0;
    end else begin
      rx_strobe <= 1'b0;
      tx_take   <= 1'b0;
      case (st)
        IDLE: begin
          pol_q <= cfg_cpol;
          pha_q <= cfg_cpha;
          if (sel) begin
            st           <= RUN;
            cnt          <= '0;
            tmo          <= '0;
            timeout_flag <= 1'b0;
            abort_flag   <= 1'b0;
            need         <= cfg_cpha;
            underrun     <= 1'b0;
            if (!cfg_cpha) begin
              tx_sr    <= tx_valid ? tx_data : '1;
              tx_take  <= tx_valid;
              underrun <= ~tx_valid;
            end
          end
        end
        RUN: begin
          if (!sel) begin
            st <= IDLE;
            if (cnt != '0) abort_flag <= 1'b1;
          end else if (tmo == cfg_limit) begin
            st           <= HALT;
            timeout_flag <= 1'b1;
          end else begin
            tmo <= sedge ? '0 : tmo + 1'b1;
            if (samp) begin
              rx_sr <= {rx_sr[DW-2:0], mosi_sh[1]};
              if (cnt == LAST) begin
                cnt       <= '0;
                rx_data   <= {rx_sr[DW-2:0], mosi_sh[1]};
                rx_strobe <= 1'b1;
                need      <= 1'b1;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            if (shft) begin
              if (need) begin
                need     <= 1'b0;
                tx_sr    <= tx_valid ? tx_data : '1;
                tx_take  <= tx_valid;
                underrun <= underrun | ~tx_valid;
              end else begin
                tx_sr <= {tx_sr[DW-2:0], 1'b1};
              end
            end
          end
        end
        default: if (!sel) st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_os_slave_chk.sv
module spi_os_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic ss_n_in,
  input logic miso_oe,
  input logic rx_strobe,
  input logic abort_flag,
  input logic tx_take,
  input logic tx_valid,
  input logic underrun,
  input logic timeout_flag,
  input logic in_run,
  input logic pol_q,
  input logic pha_q
);
  a_r7_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && $past(in_run)) |-> ($stable(pol_q) && $stable(pha_q)));

  a_r8_oe_released: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_n_in && $past(ss_n_in) && $past(ss_n_in, 2)) |=> !miso_oe);

  a_r4_abort_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abort_flag) |-> !rx_strobe);

  a_r6_underrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> (!tx_take && !$past(tx_valid)));

  a_r5_timeout_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_flag |-> !miso_oe);

  a_r3_take_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |=> !tx_take);
endmodule

bind spi_os_slave spi_os_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ss_n_in(ss_n_in), .miso_oe(miso_oe),
  .rx_strobe(rx_strobe), .abort_flag(abort_flag), .tx_take(tx_take),
  .tx_valid(tx_valid), .underrun(underrun), .timeout_flag(timeout_flag),
  .in_run(in_run), .pol_q(pol_q), .pha_q(pha_q)
);

// File: tb/spi_os_slave_bench.sv
module spi_os_slave_bench;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic [15:0] cfg_limit = 16'd40;
  logic sclk_in = 1'b0, ss_n_in = 1'b1, mosi_in = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic tx_valid = 1'b1;
  logic miso_out, miso_oe, tx_take, rx_strobe, underrun, timeout_flag, abort_flag;
  logic [7:0] rx_data;

  int n_chk = 0, n_bad = 0, rx_cnt = 0, take_cnt = 0;
  logic [7:0] rx_last = 8'h00;

  always #2 clk = ~clk;

  spi_os_slave u_spi_os_slave (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_limit(cfg_limit), .sclk_in(sclk_in), .ss_n_in(ss_n_in), .mosi_in(mosi_in),
    .miso_out(miso_out), .miso_oe(miso_oe), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_take(tx_take), .rx_data(rx_data), .rx_strobe(rx_strobe), .underrun(underrun),
    .timeout_flag(timeout_flag), .abort_flag(abort_flag)
  );

  always @(negedge clk) begin
    if (rx_strobe) begin rx_cnt <= rx_cnt + 1; rx_last <= rx_data; end
    if (tx_take) take_cnt <= take_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // Plays one frame as master; mo is left aligned; stall/flip happen before bit index given
  task automatic frame(input bit pol, input bit pha, input logic [15:0] mo, input int nbits,
                       input int stall_at, input int flip_at, output logic [15:0] mi);
    mi = '0;
    @(negedge clk);
    sclk_in = pol;
    ss_n_in = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      if (i == stall_at) repeat (100) @(negedge clk);
      if (i == flip_at) begin cfg_cpol = ~cfg_cpol; cfg_cpha = ~cfg_cpha; end
      if (!pha) begin
        mosi_in = mo[15-i];
        repeat (H) @(negedge clk);
        mi[15-i] = miso_out;
        sclk_in = ~pol;
        repeat (H) @(negedge clk);
        sclk_in = pol;
      end else begin
        repeat (H) @(negedge clk);
        sclk_in = ~pol;
        mosi_in = mo[15-i];
        repeat (H) @(negedge clk);
        mi[15-i] = miso_out;
        sclk_in = pol;
      end
    end
    repeat (H) @(negedge clk);
    ss_n_in = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  // {cpol, cpha, mosi byte, tx byte}
  localparam logic [17:0] VEC [0:7] = '{
    {1'b0, 1'b0, 8'hA5, 8'h3C}, {1'b0, 1'b1, 8'h5A, 8'hC3},
    {1'b1, 1'b0, 8'h81, 8'h7E}, {1'b1, 1'b1, 8'h01, 8'h80},
    {1'b0, 1'b0, 8'hFF, 8'h00}, {1'b0, 1'b1, 8'h00, 8'hFF},
    {1'b1, 1'b0, 8'h6D, 8'hB2}, {1'b1, 1'b1, 8'hC9, 8'h1E}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] mi;
    int r0, t0;
    // R9: reset holds outputs at default while inputs toggle
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      sclk_in = k[0]; ss_n_in = k[1]; mosi_in = k[2];
    end
    chk({miso_out, miso_oe, tx_take, rx_strobe, underrun, timeout_flag, abort_flag} == 7'd0
        && rx_data == 8'h00, "R9 reset", {miso_out, miso_oe, rx_data}, 0);
    ss_n_in = 1'b1; sclk_in = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R2 R3: table of all four modes
    for (int v = 0; v < 8; v++) begin
      cfg_cpol = VEC[v][17]; cfg_cpha = VEC[v][16];
      tx_data = VEC[v][7:0]; tx_valid = 1'b1;
      repeat (4) @(negedge clk);
      r0 = rx_cnt; t0 = take_cnt;
      frame(VEC[v][17], VEC[v][16], {VEC[v][15:8], 8'h00}, 8, -1, -1, mi);
      chk(rx_last == VEC[v][15:8] && rx_cnt == r0 + 1, "R2 rx byte", rx_last, VEC[v][15:8]);
      chk(mi[15:8] == VEC[v][7:0], "R3 miso byte", mi[15:8], VEC[v][7:0]);
      chk(take_cnt - t0 == (VEC[v][16] ? 1 : 2), "R3 fetch count", take_cnt - t0,
          VEC[v][16] ? 1 : 2);
      chk(!miso_oe && !miso_out, "R8 oe idle", miso_oe, 0);
      chk(!underrun && !abort_flag && !timeout_flag, "R1 clean flags",
          {underrun, abort_flag, timeout_flag}, 0);
    end

    // R10: two bytes back to back, mode 1
    cfg_cpol = 1'b0; cfg_cpha = 1'b1; tx_data = 8'h96;
    repeat (4) @(negedge clk);
    r0 = rx_cnt; t0 = take_cnt;
    frame(1'b0, 1'b1, 16'hA53C, 16, -1, -1, mi);
    chk(rx_cnt == r0 + 2 && rx_last == 8'h3C, "R10 second byte", rx_last, 8'h3C);
    chk(mi == 16'h9696 && take_cnt == t0 + 2, "R10 miso bytes", mi, 16'h9696);

    // R6: missing transmit data gives all ones and underrun
    tx_valid = 1'b0;
    repeat (4) @(negedge clk);
    t0 = take_cnt;
    frame(1'b0, 1'b1, 16'h4200, 8, -1, -1, mi);
    chk(mi[15:8] == 8'hFF && underrun && take_cnt == t0, "R6 underrun", mi[15:8], 8'hFF);
    tx_valid = 1'b1;

    // R4: select released after 4 bits
    cfg_cpol = 1'b0; cfg_cpha = 1'b0;
    repeat (4) @(negedge clk);
    r0 = rx_cnt;
    frame(1'b0, 1'b0, 16'hF000, 4, -1, -1, mi);
    chk(abort_flag && rx_cnt == r0, "R4 abort", {abort_flag, rx_cnt - r0}, 2);
    chk(!underrun, "R6 cleared at new frame", underrun, 0);

    // R7: mode inputs flip mid-frame, frame stays in mode 0
    repeat (4) @(negedge clk);
    r0 = rx_cnt;
    tx_data = 8'hE7;
    frame(1'b0, 1'b0, 16'h9900, 8, -1, 3, mi);
    chk(rx_last == 8'h99 && rx_cnt == r0 + 1 && mi[15:8] == 8'hE7, "R7 mode held",
        rx_last, 8'h99);
    chk(!abort_flag, "R4 abort cleared", abort_flag, 0);
    // next frame uses the new mode (cpol 1, cpha 1)
    repeat (4) @(negedge clk);
    frame(1'b1, 1'b1, 16'h3300, 8, -1, -1, mi);
    chk(rx_last == 8'h33 && mi[15:8] == 8'hE7, "R7 new mode applied", rx_last, 8'h33);

    // R5: serial clock stalls mid-frame
    cfg_cpol = 1'b0; cfg_cpha = 1'b0;
    repeat (4) @(negedge clk);
    r0 = rx_cnt;
    fork
      frame(1'b0, 1'b0, 16'hFF00, 8, 3, -1, mi);
      begin
        repeat (H + 6 * H + 4) @(negedge clk);
        chk(miso_oe, "R8 oe in frame", miso_oe, 1);
        repeat (80) @(negedge clk);
        chk(timeout_flag && !miso_oe, "R5 timeout", {timeout_flag, miso_oe}, 2);
      end
    join
    chk(rx_cnt == r0 && timeout_flag, "R5 no byte after stall", rx_cnt - r0, 0);
    repeat (4) @(negedge clk);
    frame(1'b0, 1'b0, 16'h5500, 8, -1, -1, mi);
    chk(!timeout_flag && rx_last == 8'h55, "R5 cleared at new frame", timeout_flag, 0);

    // R9: reset in the middle of a frame
    @(negedge clk);
    ss_n_in = 1'b0;
    repeat (2 * H) @(negedge clk);
    sclk_in = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk({miso_out, miso_oe, tx_take, rx_strobe, underrun, timeout_flag, abort_flag} == 7'd0
        && rx_data == 8'h00, "R9 mid-frame reset", {miso_oe, rx_data}, 0);

    summary();
    $finish;
  end
endmodule